// File: doc/BRIEF.md
# Output Frame Start Offset Calculator

This block works out where, inside an incoming video frame, a rescaled outgoing frame should begin so that the outgoing picture stays in step with its source. Given the sync widths, back porches, totals, active heights and pixel periods of both sides, it turns each side's back porch into a time, adds a margin delay of a whole number of input lines, and turns the resulting start time into a line offset and a pixel offset within the input frame. If the line offset falls outside an allowed window, it retries with a margin one line longer. It stops when the offset fits or when the margin reaches its ceiling. If the offset still does not fit, it substitutes a fixed line.

The block is a single control state machine around a shared bit-serial restoring divider. The states are IDLE (waiting for a launch), PORCH (register back-porch times, frame time, line time and the first margin factor), MARGIN (form the start time and launch the pixel-period division), DIV_PIX (wait for that quotient, then launch the division by the input line length), DIV_LINE (capture line and pixel offset) and JUDGE (retry or publish). The transitions are: launch (IDLE to PORCH on a start pulse), porch ready (PORCH to MARGIN), divide launched (MARGIN to DIV_PIX), first quotient (DIV_PIX to DIV_LINE when the divider finishes), second quotient (DIV_LINE to JUDGE), retry (JUDGE to MARGIN), and publish (JUDGE to IDLE, with a one-cycle done).

Top module: `frame_start_offset`

## Requirements
- R1: A start pulse in IDLE captures every geometry and period input. Later changes on those inputs do not affect the result of that job.
- R2: For each side, the back porch in pixels is (vertical sync + vertical back porch) * htotal + horizontal sync + horizontal back porch. Its time is that count times the same side's pixel period. The input frame time is input vtotal * input htotal * input period.
- R3: The margin is k * input htotal * input period. k starts at 5 when floor(input active height / output active height) is 2 or less. Otherwise k is 12.
- R4: With E = input porch time + margin: if E exceeds the output porch time, the start time is E minus the output porch time. Otherwise it is the input frame time minus (output porch time minus E).
- R5: The start time is divided by the input period and the fraction is dropped. The result is divided by input htotal. The quotient is the line offset and the remainder is the pixel offset.
- R6: While the line offset is below 2 or above 14 and k is below 12, k is raised by one and the calculation is repeated.
- R7: If the final line offset is still outside 2..14, the line output is 4. The pixel output keeps the last remainder.
- R8: done is high for exactly one cycle per accepted start. line_ofs and pixel_ofs change only in that cycle and hold their values otherwise.
- R9: A start pulse that arrives while a job is in progress is ignored. It produces no extra done and does not alter the running result.
- R10: After reset, line_ofs and pixel_ofs are 0 and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, honoured only in IDLE |
| src_vsync | input | TIM_W | Input vertical sync width, lines |
| src_vbp | input | TIM_W | Input vertical back porch, lines |
| src_hsync | input | TIM_W | Input horizontal sync width, pixels |
| src_hbp | input | TIM_W | Input horizontal back porch, pixels |
| src_htotal | input | TIM_W | Input pixels per line |
| src_vtotal | input | TIM_W | Input lines per frame |
| src_vactive | input | TIM_W | Input active height |
| src_period | input | PER_W | Input pixel period |
| dst_vsync | input | TIM_W | Output vertical sync width |
| dst_vbp | input | TIM_W | Output vertical back porch |
| dst_hsync | input | TIM_W | Output horizontal sync width |
| dst_hbp | input | TIM_W | Output horizontal back porch |
| dst_htotal | input | TIM_W | Output pixels per line |
| dst_vactive | input | TIM_W | Output active height |
| dst_period | input | PER_W | Output pixel period |
| line_ofs | output | TIM_W | Start line offset within the input frame |
| pixel_ofs | output | TIM_W | Start pixel offset within that line |
| done | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that input htotal, input period and output active height are non-zero when a job is launched. They also assume that, on the wrapped branch, the output porch lead never exceeds one input frame, so the wrapped subtraction stays positive. The stimulus keeps every period and total at 1 or more. Randomised geometries are screened by the bench model, which discards any set whose wrapped start time would go negative before it reaches the block. Junk values placed on the inputs while a job is in progress, including an ignored second launch, also keep non-zero periods and totals.

// File: rtl/fso_pkg.sv
package fso_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PORCH,
        S_MARGIN,
        S_DIV_PIX,
        S_DIV_LINE,
        S_JUDGE
    } fso_state_t;

    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;
    localparam int N_SIDES  = 2;

endpackage

// File: rtl/fso_porch_count.sv
module fso_porch_count #(
    parameter int TIM_W  = 16,
    parameter int PER_W  = 16,
    parameter int TIME_W = 64
) (
    input  logic [TIM_W-1:0]  vsync,
    input  logic [TIM_W-1:0]  vbp,
    input  logic [TIM_W-1:0]  hsync,
    input  logic [TIM_W-1:0]  hbp,
    input  logic [TIM_W-1:0]  htotal,
    input  logic [PER_W-1:0]  period,
    output logic [TIME_W-1:0] porch_px,
    output logic [TIME_W-1:0] porch_time
);
    logic [TIME_W-1:0] lead_lines;

    // R2: blanking lines before active video, widened before any product
    always_comb begin
        lead_lines = TIME_W'(vsync) + TIME_W'(vbp);
        porch_px   = lead_lines * TIME_W'(htotal) + TIME_W'(hsync) + TIME_W'(hbp);
        porch_time = porch_px * TIME_W'(period);
    end
endmodule

// File: rtl/fso_seq_divider.sv
module fso_seq_divider #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, dsr_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q, done_q;
    logic [W:0]    rem_shift, trial;
    logic [W-1:0]  rem_nx, quo_nx;

    // one restoring step per cycle: shift in the next dividend bit, try a subtract
    always_comb begin
        rem_shift = {rem_q, quo_q[W-1]};
        trial     = rem_shift - {1'b0, dsr_q};
        if (!trial[W]) begin
            rem_nx = trial[W-1:0];
            quo_nx = {quo_q[W-2:0], 1'b1};
        end else begin
            rem_nx = rem_shift[W-1:0];
            quo_nx = {quo_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dsr_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (start && !busy_q) begin
            rem_q  <= '0;
            quo_q  <= dividend;
            dsr_q  <= divisor;
            cnt_q  <= CW'(W);
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            rem_q  <= rem_nx;
            quo_q  <= quo_nx;
            cnt_q  <= cnt_q - 1'b1;
            busy_q <= (cnt_q != CW'(1));
            done_q <= (cnt_q == CW'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done      = done_q;
    assign quotient  = quo_q;
    assign remainder = rem_q;

    // R5: operand assumption, a launched division never has a zero divisor
    assert_divisor_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q) |-> (divisor != '0));

    // R5: a finished division leaves a remainder smaller than its divisor
    assert_rem_below_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (rem_q < dsr_q));

    assert_done_single_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/frame_start_offset.sv
module frame_start_offset
    import fso_pkg::*;
#(
    parameter int TIM_W         = 16,
    parameter int PER_W         = 16,
    parameter int TIME_W        = 64,
    parameter int K_NEAR        = 5,
    parameter int K_FAR         = 12,
    parameter int WIN_LO        = 2,
    parameter int WIN_HI        = 14,
    parameter int LINE_FALLBACK = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TIM_W-1:0] src_vsync,
    input  logic [TIM_W-1:0] src_vbp,
    input  logic [TIM_W-1:0] src_hsync,
    input  logic [TIM_W-1:0] src_hbp,
    input  logic [TIM_W-1:0] src_htotal,
    input  logic [TIM_W-1:0] src_vtotal,
    input  logic [TIM_W-1:0] src_vactive,
    input  logic [PER_W-1:0] src_period,
    input  logic [TIM_W-1:0] dst_vsync,
    input  logic [TIM_W-1:0] dst_vbp,
    input  logic [TIM_W-1:0] dst_hsync,
    input  logic [TIM_W-1:0] dst_hbp,
    input  logic [TIM_W-1:0] dst_htotal,
    input  logic [TIM_W-1:0] dst_vactive,
    input  logic [PER_W-1:0] dst_period,
    output logic [TIM_W-1:0] line_ofs,
    output logic [TIM_W-1:0] pixel_ofs,
    output logic             done
);
    localparam int K_W = $clog2(K_FAR + 1);

    fso_state_t state_q, state_d;

    // captured job parameters, indexed by side
    logic [TIM_W-1:0]  vs_q   [N_SIDES];
    logic [TIM_W-1:0]  vbp_q  [N_SIDES];
    logic [TIM_W-1:0]  hs_q   [N_SIDES];
    logic [TIM_W-1:0]  hbp_q  [N_SIDES];
    logic [TIM_W-1:0]  ht_q   [N_SIDES];
    logic [TIM_W-1:0]  va_q   [N_SIDES];
    logic [PER_W-1:0]  per_q  [N_SIDES];
    logic [TIM_W-1:0]  src_vt_q;

    logic [TIME_W-1:0] porch_px_w   [N_SIDES];
    logic [TIME_W-1:0] porch_time_w [N_SIDES];

    logic [TIME_W-1:0] t_in_q, t_out_q, t_frame_q, t_line_q;
    logic [K_W-1:0]    k_q;
    logic [TIME_W-1:0] line_raw_q, pix_raw_q;

    logic [TIME_W-1:0] t_margin, t_early, t_start;
    logic              small_ratio, in_window, retry;

    logic              div_start, div_done;
    logic [TIME_W-1:0] div_dvd, div_dsr, div_quo, div_rem;

    // ---------------- porch arithmetic, one unit per side ----------------
    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        fso_porch_count #(
            .TIM_W (TIM_W),
            .PER_W (PER_W),
            .TIME_W(TIME_W)
        ) u_porch (
            .vsync     (vs_q[s]),
            .vbp       (vbp_q[s]),
            .hsync     (hs_q[s]),
            .hbp       (hbp_q[s]),
            .htotal    (ht_q[s]),
            .period    (per_q[s]),
            .porch_px  (porch_px_w[s]),
            .porch_time(porch_time_w[s])
        );
    end

    // ---------------- start time and window tests ----------------
    always_comb begin
        // R3: floor(a/b) <= 2 exactly when a < 3*b
        small_ratio = TIME_W'(va_q[SIDE_SRC]) < (TIME_W'(va_q[SIDE_DST]) * TIME_W'(3));
        t_margin    = TIME_W'(k_q) * t_line_q;
        t_early     = t_in_q + t_margin;
        // R4: direct difference, or wrap into the previous input frame
        if (t_early > t_out_q)
            t_start = t_early - t_out_q;
        else
            t_start = t_frame_q - (t_out_q - t_early);
        in_window = (line_raw_q >= TIME_W'(WIN_LO)) && (line_raw_q <= TIME_W'(WIN_HI));
        retry     = !in_window && (k_q < K_W'(K_FAR));
    end

    // ---------------- shared divider ----------------
    always_comb begin
        div_start = 1'b0;
        div_dvd   = div_quo;
        div_dsr   = TIME_W'(ht_q[SIDE_SRC]);
        if (state_q == S_MARGIN) begin
            div_start = 1'b1;
            div_dvd   = t_start;
            div_dsr   = TIME_W'(per_q[SIDE_SRC]);
        end else if (state_q == S_DIV_PIX && div_done) begin
            div_start = 1'b1;
        end
    end

    fso_seq_divider #(.W(TIME_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_dvd),
        .divisor  (div_dsr),
        .done     (div_done),
        .quotient (div_quo),
        .remainder(div_rem)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = S_PORCH;
            S_PORCH:    state_d = S_MARGIN;
            S_MARGIN:   state_d = S_DIV_PIX;
            S_DIV_PIX:  if (div_done) state_d = S_DIV_LINE;
            S_DIV_LINE: if (div_done) state_d = S_JUDGE;
            S_JUDGE:    state_d = retry ? S_MARGIN : S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < N_SIDES; s++) begin
                vs_q[s]  <= '0;
                vbp_q[s] <= '0;
                hs_q[s]  <= '0;
                hbp_q[s] <= '0;
                ht_q[s]  <= '0;
                va_q[s]  <= '0;
                per_q[s] <= '0;
            end
            src_vt_q   <= '0;
            t_in_q     <= '0;
            t_out_q    <= '0;
            t_frame_q  <= '0;
            t_line_q   <= '0;
            k_q        <= '0;
            line_raw_q <= '0;
            pix_raw_q  <= '0;
            line_ofs   <= '0;
            pixel_ofs  <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        // R1: capture the whole job; R9: only reachable here
                        vs_q[SIDE_SRC]  <= src_vsync;
                        vbp_q[SIDE_SRC] <= src_vbp;
                        hs_q[SIDE_SRC]  <= src_hsync;
                        hbp_q[SIDE_SRC] <= src_hbp;
                        ht_q[SIDE_SRC]  <= src_htotal;
                        va_q[SIDE_SRC]  <= src_vactive;
                        per_q[SIDE_SRC] <= src_period;
                        vs_q[SIDE_DST]  <= dst_vsync;
                        vbp_q[SIDE_DST] <= dst_vbp;
                        hs_q[SIDE_DST]  <= dst_hsync;
                        hbp_q[SIDE_DST] <= dst_hbp;
                        ht_q[SIDE_DST]  <= dst_htotal;
                        va_q[SIDE_DST]  <= dst_vactive;
                        per_q[SIDE_DST] <= dst_period;
                        src_vt_q        <= src_vtotal;
                    end
                end
                S_PORCH: begin
                    t_in_q    <= porch_time_w[SIDE_SRC];
                    t_out_q   <= porch_time_w[SIDE_DST];
                    t_line_q  <= TIME_W'(ht_q[SIDE_SRC]) * TIME_W'(per_q[SIDE_SRC]);
                    t_frame_q <= TIME_W'(src_vt_q) * TIME_W'(ht_q[SIDE_SRC])
                                 * TIME_W'(per_q[SIDE_SRC]);
                    k_q       <= small_ratio ? K_W'(K_NEAR) : K_W'(K_FAR);
                end
                S_MARGIN: begin
                end
                S_DIV_PIX: begin
                end
                S_DIV_LINE: begin
                    if (div_done) begin
                        line_raw_q <= div_quo;
                        pix_raw_q  <= div_rem;
                    end
                end
                S_JUDGE: begin
                    if (retry) begin
                        k_q <= k_q + 1'b1;
                    end else begin
                        line_ofs  <= in_window ? line_raw_q[TIM_W-1:0] : TIM_W'(LINE_FALLBACK);
                        pixel_ofs <= pix_raw_q[TIM_W-1:0];
                        done      <= 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(line_ofs) && $stable(pixel_ofs)));

    assert_line_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (line_ofs >= TIM_W'(WIN_LO) && line_ofs <= TIM_W'(WIN_HI)));

    assert_pix_below_htotal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pixel_ofs < ht_q[SIDE_SRC]));

    assert_k_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MARGIN || state_q == S_JUDGE)
            |-> (k_q >= K_W'(K_NEAR) && k_q <= K_W'(K_FAR)));

    assert_k_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PORCH) |=> (k_q == K_W'(K_NEAR) || k_q == K_W'(K_FAR)));

    assert_capture_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> ($stable(ht_q[SIDE_SRC]) && $stable(per_q[SIDE_SRC])));

    assert_done_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == S_IDLE));
endmodule

// File: tb/frame_start_offset_tb.sv
module frame_start_offset_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCFG       = 15;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] s_vs, s_vbp, s_hs, s_hbp, s_ht, s_vt, s_va, s_per;
    logic [15:0] d_vs, d_vbp, d_hs, d_hbp, d_ht, d_va, d_per;
    logic [15:0] line_ofs, pixel_ofs;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    bit    pending  = 1'b0;
    int    exp_line = 0, exp_pix = 0;
    int    held_line = 0, held_pix = 0;
    string exp_tags = "";

    always #(CLK_PERIOD / 2) clk = ~clk;

    frame_start_offset u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_vsync(s_vs), .src_vbp(s_vbp), .src_hsync(s_hs), .src_hbp(s_hbp),
        .src_htotal(s_ht), .src_vtotal(s_vt), .src_vactive(s_va), .src_period(s_per),
        .dst_vsync(d_vs), .dst_vbp(d_vbp), .dst_hsync(d_hs), .dst_hbp(d_hbp),
        .dst_htotal(d_ht), .dst_vactive(d_va), .dst_period(d_per),
        .line_ofs(line_ofs), .pixel_ofs(pixel_ofs), .done(done)
    );

    // behavioural reference straight from the requirement text
    function automatic void model(input int c[NCFG], output int line, output int pix,
                                  output bit ok);
        longint unsigned bpi, bpo, ti, to, tf, d, e, t, q, ln;
        int k;
        ok  = 1'b1;
        bpi = (longint'(c[1]) + c[0]) * c[4] + c[2] + c[3];       // R2
        bpo = (longint'(c[9]) + c[8]) * c[12] + c[10] + c[11];
        ti  = bpi * c[7];
        to  = bpo * c[14];
        tf  = longint'(c[5]) * c[4] * c[7];
        k   = ((c[6] / c[13]) <= 2) ? 5 : 12;                     // R3
        while (1) begin
            d = longint'(k) * c[4] * c[7];
            e = ti + d;
            if (e > to) t = e - to;                                // R4
            else begin
                if ((to - e) > tf) ok = 1'b0;
                t = tf - (to - e);
            end
            q   = t / c[7];                                        // R5
            ln  = q / c[4];
            pix = int'(q % c[4]);
            if ((ln < 2 || ln > 14) && k < 12) k++;                // R6
            else break;
        end
        line = (ln < 2 || ln > 14) ? 4 : int'(ln);                 // R7
    endfunction

    task automatic drive(input int c[NCFG]);
        s_vs = 16'(c[0]);  s_vbp = 16'(c[1]);  s_hs = 16'(c[2]);  s_hbp = 16'(c[3]);
        s_ht = 16'(c[4]);  s_vt = 16'(c[5]);   s_va = 16'(c[6]);  s_per = 16'(c[7]);
        d_vs = 16'(c[8]);  d_vbp = 16'(c[9]);  d_hs = 16'(c[10]); d_hbp = 16'(c[11]);
        d_ht = 16'(c[12]); d_va = 16'(c[13]);  d_per = 16'(c[14]);
    endtask

    task automatic scramble();
        int c[NCFG];
        for (int i = 0; i < NCFG; i++) c[i] = 1 + int'($urandom_range(0, 900));
        drive(c);
    endtask

    task automatic run_job(input int c[NCFG], input string tags, input bit intrude);
        int el, ep;
        bit ok;
        model(c, el, ep, ok);
        if (!ok) begin
            $display("note: skipped geometry with negative wrapped start");
            return;
        end
        @(posedge clk); #1;
        drive(c);
        start    = 1'b1;
        exp_line = el;
        exp_pix  = ep;
        exp_tags = tags;
        pending  = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        scramble();                                                // R1
        if (intrude) begin                                         // R9
            repeat (20) @(posedge clk);
            #1;
            scramble();
            start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        while (pending) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    // per-clock comparison against the model's held and pending results
    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            n_checks++;
            if (done) begin
                if (!pending) begin
                    n_fails++;
                    $display("FAIL R8/R9: done without a job, line=%0d pix=%0d expected no done",
                             line_ofs, pixel_ofs);
                end else if (line_ofs != exp_line || pixel_ofs != exp_pix) begin
                    n_fails++;
                    $display("FAIL %s: line=%0d pix=%0d expected line=%0d pix=%0d",
                             exp_tags, line_ofs, pixel_ofs, exp_line, exp_pix);
                end
                held_line = exp_line;
                held_pix  = exp_pix;
                pending   = 1'b0;
            end else if (line_ofs != held_line || pixel_ofs != held_pix) begin
                n_fails++;
                $display("FAIL R8 hold: line=%0d pix=%0d expected line=%0d pix=%0d",
                         line_ofs, pixel_ofs, held_line, held_pix);
            end
            if (cycles > WATCHDOG) begin
                n_fails++;
                $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        int base[NCFG];
        int c[NCFG];
        int rl, rp;
        bit ok;
        base = '{5, 36, 44, 148, 2200, 1125, 1080, 6, 5, 20, 40, 220, 1650, 720, 13};
        drive(base);
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (line_ofs !== 16'd0 || pixel_ofs !== 16'd0 || done !== 1'b0) begin
            n_fails++;
            $display("FAIL R10: line=%0d pix=%0d done=%0b expected 0 0 0",
                     line_ofs, pixel_ofs, done);
        end

        // direct branch, in window at first try (expect line 5, pixel 453)
        run_job(base, "R1 R2 R4 R5 direct", 1'b0);
        // wrapped branch landing in window
        c = base; c[9] = 712;
        run_job(c, "R4 R5 wrapped", 1'b0);
        // wrapped branch far outside: retries exhaust, fallback line 4
        c = base; c[9] = 200;
        run_job(c, "R6 R7 fallback", 1'b0);
        // two retries before the offset fits (k ends at 7)
        c = base; c[9] = 23;
        run_job(c, "R6 retry", 1'b0);
        // ratio exactly 2 keeps k=5
        c = base; c[13] = 540;
        run_job(c, "R3 ratio two", 1'b0);
        // ratio 3 forces k=12
        c = base; c[13] = 360;
        run_job(c, "R3 ratio three", 1'b0);
        c = base; c[13] = 300;
        run_job(c, "R3 far margin", 1'b0);
        // far margin with no retry room, fallback
        c = base; c[13] = 300; c[9] = 200;
        run_job(c, "R7 far fallback", 1'b0);
        // second launch during a job is ignored
        run_job(base, "R9 ignored launch", 1'b1);
        c = base; c[9] = 23;
        run_job(c, "R9 ignored launch retry", 1'b1);

        // randomised geometries screened by the model
        for (int j = 0; j < 14; j++) begin
            ok = 1'b0;
            while (!ok) begin
                c[0]  = int'($urandom_range(1, 10));
                c[1]  = int'($urandom_range(1, 60));
                c[2]  = int'($urandom_range(1, 80));
                c[3]  = int'($urandom_range(1, 200));
                c[4]  = int'($urandom_range(400, 3000));
                c[6]  = int'($urandom_range(100, 1200));
                c[5]  = c[6] + c[0] + c[1] + int'($urandom_range(1, 40));
                c[7]  = int'($urandom_range(1, 40));
                c[8]  = int'($urandom_range(1, 10));
                c[9]  = int'($urandom_range(1, 60));
                c[10] = int'($urandom_range(1, 80));
                c[11] = int'($urandom_range(1, 200));
                c[12] = int'($urandom_range(400, 3000));
                c[13] = int'($urandom_range(100, 1200));
                c[14] = int'($urandom_range(1, 40));
                model(c, rl, rp, ok);
            end
            run_job(c, "R2 R3 R4 R5 R6 R7 random", (j % 4) == 3);
        end

        repeat (50) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule